// File: doc/BRIEF.md
# Idle Deep Power-Down Controller

This block decides when an Ethernet transceiver may drop into its deepest power-saving state. It watches two inputs: a link-status flag, which is high while energy is received from the partner, and the transmit enable driven by the MAC. When the link is down and transmit enable is low, the port counts as idle. If that condition lasts without a break for a long timeout, about 32 seconds at the nominal reference clock, the block enters power-down.

In power-down it asserts power-down controls for four analog sections: the transmit PLL, the receiver with its equalizer, the transmit DAC and the clock-data recovery. Each control is masked by its own bit of a five-bit configuration field. A master bit in that field enables the feature as a whole. While the transmit DAC is powered down, the block also requests high impedance on the transmit output driver. Any break in the idle condition clears the timeout counter and, if the block is in power-down, releases every section at the next clock edge. A status output reports whether power-down is active.

The timeout length is computed from parameters for the clock frequency, the idle time in seconds and a divisor. The divisor lets a simulation build use a short timeout.

Top module: `idle_pdn_ctrl`

## Requirements
- R1: The port is idle only while `link_up` is low and `tx_en` is low. While either input is high, `in_pdn` stays low however long that lasts.
- R2: Let TIMEOUT = CLK_HZ*IDLE_SEC/SIM_DIV (at least 1). `in_pdn` goes high at the TIMEOUT-th consecutive rising clock edge that samples the port idle with the master enable set. After TIMEOUT-1 such edges it is still low.
- R3: The section outputs equal `in_pdn` ANDed with their own bit of `pdn_cfg`: bit 3 drives `pd_tpll`, bit 2 `pd_rxeq`, bit 1 `pd_txdac` and bit 0 `pd_cdr`. A change of these bits during power-down takes effect on the outputs without a clock edge.
- R4: `tx_drv_hiz` is high exactly when `pd_txdac` is high.
- R5: `pdn_cfg` bit 4 is the master enable. While it is clear, `in_pdn` is not set. Clearing it during power-down drops `in_pdn` and all section outputs at the next rising edge.
- R6: A clock edge that samples the port not idle clears the timeout count and drops `in_pdn` at that edge. Power-down then needs a full new TIMEOUT of idle edges.
- R7: The timeout keeps running while the master enable is clear. If the idle time has already reached TIMEOUT when the master bit is set, `in_pdn` rises at the next rising edge.
- R8: An active-low `rst_n` clears the count and `in_pdn` at once, so every output is low. After reset, power-down needs a full TIMEOUT of idle edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| link_up | input | 1 | High while energy from the link partner is present |
| tx_en | input | 1 | MAC transmit enable, synchronous to clk |
| pdn_cfg | input | 5 | Bit 4 master enable, bit 3 PLL, bit 2 receiver/equalizer, bit 1 DAC, bit 0 clock-data recovery |
| pd_tpll | output | 1 | Power down transmit PLL |
| pd_rxeq | output | 1 | Power down receiver and equalizer |
| pd_txdac | output | 1 | Power down transmit DAC |
| pd_cdr | output | 1 | Power down clock-data recovery |
| tx_drv_hiz | output | 1 | Place transmit output driver in high impedance |
| in_pdn | output | 1 | Status: power-down is active |

## Verification
The bench builds the block with CLK_HZ=40, IDLE_SEC=1 and SIM_DIV=2, which gives a timeout of 20 clock cycles. With that value the exact entry edge can be reached: the bench probes 19 and 20 idle edges, several wake-and-retry cycles, and a master enable that is set after the timeout has already elapsed, all within a few hundred cycles. The default build keeps the 32-second timeout at 50 MHz and needs a 31-bit counter. The bench does not simulate that length.

// File: rtl/idle_pdn_pkg.sv
package idle_pdn_pkg;

  localparam int CFG_W      = 5;
  localparam int SECT_N     = 4;
  localparam int CFG_CDR    = 0;
  localparam int CFG_TXDAC  = 1;
  localparam int CFG_RXEQ   = 2;
  localparam int CFG_TPLL   = 3;
  localparam int CFG_MASTER = 4;

  // Number of idle clock edges before power-down; never below one.
  function automatic longint timeout_cycles(longint clk_hz, longint secs, longint div);
    longint n;
    n = (div > 0) ? (clk_hz * secs) / div : clk_hz * secs;
    return (n < 1) ? 64'sd1 : n;
  endfunction

  // Counter width able to hold limit-1, at least one bit.
  function automatic int count_width(longint limit);
    int w;
    w = $clog2(limit);
    return (w < 1) ? 1 : w;
  endfunction

  // Per-section gating: section i is down when active and its mask bit set.
  function automatic logic [SECT_N-1:0] gate_sections(logic active, logic [CFG_W-1:0] cfg);
    return {SECT_N{active}} & cfg[SECT_N-1:0];
  endfunction

endpackage

// File: rtl/idle_pdn_detect.sv
module idle_pdn_detect (
  input  logic link_up,
  input  logic tx_en,
  output logic idle_now
);
  // Idle only when neither received energy nor transmit activity is present.
  assign idle_now = ~link_up & ~tx_en;
endmodule

// File: rtl/idle_pdn_timer.sv
module idle_pdn_timer #(
  parameter longint LIMIT = 64'sd20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic idle_now,
  output logic elapsed
);
  import idle_pdn_pkg::*;

  localparam int            CW   = count_width(LIMIT);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (!idle_now)      cnt_q <= '0;
    else if (cnt_q != LAST)  cnt_q <= cnt_q + 1'b1;
  end

  // Idle has lasted LIMIT edges once this edge is taken.
  assign elapsed = idle_now && (cnt_q == LAST);

  // R6
  cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !idle_now |=> (cnt_q == '0));

  // R2
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_now && cnt_q != LAST) |=> (cnt_q == $past(cnt_q) + 1'b1));

endmodule

// File: rtl/idle_pdn_state.sv
module idle_pdn_state (
  input  logic clk,
  input  logic rst_n,
  input  logic idle_now,
  input  logic master_en,
  input  logic elapsed,
  output logic in_pdn
);
  logic pdn_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      pdn_q <= 1'b0;
    else if (!idle_now || !master_en) pdn_q <= 1'b0;
    else if (elapsed)                pdn_q <= 1'b1;
  end

  assign in_pdn = pdn_q;

  // R6
  wake_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !idle_now |=> !in_pdn);

  // R5
  master_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !master_en |=> !in_pdn);

  // R2
  entry_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_pdn) |-> $past(elapsed));

endmodule

// File: rtl/idle_pdn_gate.sv
module idle_pdn_gate (
  input  logic                              active,
  input  logic [idle_pdn_pkg::CFG_W-1:0]    cfg,
  output logic [idle_pdn_pkg::SECT_N-1:0]   pd,
  output logic                              drv_hiz
);
  import idle_pdn_pkg::*;

  logic [SECT_N-1:0] gated;
  assign gated = gate_sections(active, cfg);

  for (genvar i = 0; i < SECT_N; i++) begin : g_sect
    assign pd[i] = gated[i];
  end

  // Driver floats whenever the DAC behind it is unpowered.
  assign drv_hiz = pd[CFG_TXDAC];
endmodule

// File: rtl/idle_pdn_ctrl.sv
module idle_pdn_ctrl #(
  parameter longint CLK_HZ   = 64'sd50_000_000,
  parameter longint IDLE_SEC = 64'sd32,
  parameter longint SIM_DIV  = 64'sd1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       link_up,
  input  logic       tx_en,
  input  logic [4:0] pdn_cfg,
  output logic       pd_tpll,
  output logic       pd_rxeq,
  output logic       pd_txdac,
  output logic       pd_cdr,
  output logic       tx_drv_hiz,
  output logic       in_pdn
);
  import idle_pdn_pkg::*;

  localparam longint LIMIT = timeout_cycles(CLK_HZ, IDLE_SEC, SIM_DIV);

  logic              idle_now;
  logic              elapsed;
  logic              pdn_act;
  logic [SECT_N-1:0] pd_vec;
  logic              hiz;

  idle_pdn_detect u_detect (
    .link_up  (link_up),
    .tx_en    (tx_en),
    .idle_now (idle_now)
  );

  idle_pdn_timer #(.LIMIT(LIMIT)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .idle_now (idle_now),
    .elapsed  (elapsed)
  );

  idle_pdn_state u_state (
    .clk       (clk),
    .rst_n     (rst_n),
    .idle_now  (idle_now),
    .master_en (pdn_cfg[CFG_MASTER]),
    .elapsed   (elapsed),
    .in_pdn    (pdn_act)
  );

  idle_pdn_gate u_gate (
    .active  (pdn_act),
    .cfg     (pdn_cfg),
    .pd      (pd_vec),
    .drv_hiz (hiz)
  );

  assign pd_tpll    = pd_vec[CFG_TPLL];
  assign pd_rxeq    = pd_vec[CFG_RXEQ];
  assign pd_txdac   = pd_vec[CFG_TXDAC];
  assign pd_cdr     = pd_vec[CFG_CDR];
  assign tx_drv_hiz = hiz;
  assign in_pdn     = pdn_act;

  // R3
  sect_needs_pdn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_vec != '0) |-> in_pdn);

  // R4
  hiz_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_drv_hiz |-> (in_pdn && pdn_cfg[CFG_TXDAC]));

  // R1
  busy_no_pdn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (link_up || tx_en) |=> !in_pdn);

endmodule

// File: tb/idle_pdn_ctrl_bench.sv
module idle_pdn_ctrl_bench;

  // Bench timeout: 40 * 1 / 2 = 20 idle edges.
  localparam int T = 20;

  typedef struct packed {
    logic       link;
    logic       tx;
    logic [4:0] cfg;
    logic [7:0] hold;
    logic       pdn;
    logic [3:0] pd;   // {tpll, rxeq, txdac, cdr}
    logic       hiz;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b0, 5'h1F, 8'd30, 1'b0, 4'h0, 1'b0, 4'd1}, // R1 link up blocks
    '{1'b0, 1'b1, 5'h1F, 8'd30, 1'b0, 4'h0, 1'b0, 4'd1}, // R1 tx_en blocks
    '{1'b0, 1'b0, 5'h1F, 8'd19, 1'b0, 4'h0, 1'b0, 4'd2}, // R2 one short
    '{1'b0, 1'b0, 5'h1F, 8'd1,  1'b1, 4'hF, 1'b1, 4'd2}, // R2 entry
    '{1'b0, 1'b0, 5'h1A, 8'd1,  1'b1, 4'hA, 1'b1, 4'd3}, // R3 R4 mask
    '{1'b0, 1'b0, 5'h15, 8'd1,  1'b1, 4'h5, 1'b0, 4'd4}, // R3 R4 DAC up
    '{1'b0, 1'b0, 5'h0F, 8'd1,  1'b0, 4'h0, 1'b0, 4'd5}, // R5 master off
    '{1'b0, 1'b0, 5'h1F, 8'd1,  1'b1, 4'hF, 1'b1, 4'd7}, // R7 late enable
    '{1'b0, 1'b1, 5'h1F, 8'd1,  1'b0, 4'h0, 1'b0, 4'd6}, // R6 tx wake
    '{1'b0, 1'b0, 5'h1F, 8'd19, 1'b0, 4'h0, 1'b0, 4'd6}, // R6 count cleared
    '{1'b0, 1'b0, 5'h1F, 8'd1,  1'b1, 4'hF, 1'b1, 4'd6}, // R6 re-entry
    '{1'b1, 1'b0, 5'h1F, 8'd1,  1'b0, 4'h0, 1'b0, 4'd6}, // R6 link wake
    '{1'b0, 1'b0, 5'h10, 8'd20, 1'b1, 4'h0, 1'b0, 4'd3}  // R3 empty mask
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       link_up = 1'b1;
  logic       tx_en = 1'b0;
  logic [4:0] pdn_cfg = 5'h1F;
  logic       pd_tpll, pd_rxeq, pd_txdac, pd_cdr, tx_drv_hiz, in_pdn;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  idle_pdn_ctrl #(.CLK_HZ(64'sd40), .IDLE_SEC(64'sd1), .SIM_DIV(64'sd2)) u_idle_pdn_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .link_up    (link_up),
    .tx_en      (tx_en),
    .pdn_cfg    (pdn_cfg),
    .pd_tpll    (pd_tpll),
    .pd_rxeq    (pd_rxeq),
    .pd_txdac   (pd_txdac),
    .pd_cdr     (pd_cdr),
    .tx_drv_hiz (tx_drv_hiz),
    .in_pdn     (in_pdn)
  );

  task automatic check(input logic epdn, input logic [3:0] epd, input logic ehiz,
                       input string tag);
    logic [5:0] act, exp;
    act = {in_pdn, pd_tpll, pd_rxeq, pd_txdac, pd_cdr, tx_drv_hiz};
    exp = {epdn, epd, ehiz};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: {pdn,pd[3:0],hiz} actual %b expected %b", tag, act, exp);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(1'b0, 4'h0, 1'b0, "R8 reset state");
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      link_up = VECS[i].link;
      tx_en   = VECS[i].tx;
      pdn_cfg = VECS[i].cfg;
      for (int k = 0; k < int'(VECS[i].hold); k++) @(posedge clk);
      @(negedge clk);
      check(VECS[i].pdn, VECS[i].pd, VECS[i].hiz,
            $sformatf("R%0d vector %0d", VECS[i].req, i));
    end

    // R8: reset in power-down clears everything at once
    rst_n = 1'b0;
    #1;
    check(1'b0, 4'h0, 1'b0, "R8 async reset");
    @(negedge clk);
    link_up = 1'b0; tx_en = 1'b0; pdn_cfg = 5'h1F;
    rst_n = 1'b1;
    repeat (T - 1) @(posedge clk);
    @(negedge clk);
    check(1'b0, 4'h0, 1'b0, "R8 full timeout after reset");
    @(posedge clk);
    @(negedge clk);
    check(1'b1, 4'hF, 1'b1, "R2 entry after reset");

    // R3: mask change in power-down applies without a clock edge
    pdn_cfg = 5'h14;
    #1;
    check(1'b1, 4'h4, 1'b0, "R3 combinational mask");

    // R1: one busy edge in a long idle run blocks entry
    @(negedge clk);
    pdn_cfg = 5'h1F; link_up = 1'b1;
    @(negedge clk);
    link_up = 1'b0;
    repeat (T - 1) @(posedge clk);
    @(negedge clk);
    check(1'b0, 4'h0, 1'b0, "R1 restart after brief link");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule